// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Incrementer

This block adds two 128-bit unsigned operands and a carry-in, producing a 128-bit sum and a carry-out. It is purely combinational. The operand width is split into fourteen ripple groups that grow wider toward the most significant end, so that each group finishes its local addition at about the time its select carry arrives from below.

The lowest group is a plain ripple adder fed by the external carry-in. Every higher group computes its result for an incoming carry of zero with one ripple adder. It then forms its result for an incoming carry of one by incrementing that result in a converter one bit wider than the group. A multiplexer per group picks one of the two results using the carry from the group below. The top bit of the chosen result is passed on as that group's carry.

A build-time switch replaces the incrementer with a second ripple adder whose carry-in is tied to one. This regular form can then be compared against the incrementer form, and both give the same sums.

Top module: `sqrt_csel_add`

## Requirements
- R1: With `USE_INC` = 1 (default), {co, sum} equals a + b + ci for every input combination.
- R2: With `USE_INC` = 0 (two ripple adders per upper group), {co, sum} also equals a + b + ci, identical to the incrementer form.
- R3: In every upper group, the carry-one candidate (n+1 bits: carry above n sum bits) equals the carry-zero candidate plus one, modulo 2^(n+1).
- R4: Each upper group outputs its carry-zero candidate when the carry from the group below is 0, and its carry-one candidate when that carry is 1; the candidate's top bit is the carry into the next group.
- R5: The lowest group is a single ripple adder driven directly by ci: with a = b = 0 and ci = 1, sum = 1 and co = 0.
- R6: Group sizes come from `GSZ`, least significant group first, default 2,3,4,5,6,7,8,9,10,11,12,13,14,24, and must sum to `WIDTH`; a carry generated just below any group boundary lands on the first bit of the next group.
- R7: All ones plus one with ci = 0 gives sum = 0 and co = 1; with ci = 1 it gives sum = 1 and co = 1.
- R8: A carry-in travels the full width: all ones plus zero with ci = 1 gives sum = 0 and co = 1; zero plus zero with ci = 0 gives sum = 0 and co = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 128 | First operand |
| b | input | 128 | Second operand |
| ci | input | 1 | Carry into bit 0 |
| sum | output | 128 | Low 128 bits of a + b + ci |
| co | output | 1 | Carry out of bit 127 |

## Verification
The block has no registers, so sum and co are due in the same cycle as the operands change, with zero cycles of latency. The bench drives each vector on a falling clock edge and samples both instances a quarter period later, well after the logic has settled and away from any edge. Each vector is compared against a 129-bit sum computed in the bench for the incrementer and the regular instance alike. The vectors cover wrap-around at all ones, full-length carry-in travel, alternating bits, a carry forced across each group boundary, and random operands.

// File: rtl/sqrt_csel_add.sv
module sqrt_csel_add #(
  parameter int WIDTH = 128,
  parameter int NGRP = 14,
  parameter int GSZ [NGRP] = '{2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 24},
  parameter bit USE_INC = 1'b1
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             ci,
  output logic [WIDTH-1:0] sum,
  output logic             co
);

  function automatic int base_of(int g);
    int s;
    s = 0;
    for (int k = 0; k < g; k++) s += GSZ[k];
    return s;
  endfunction

  logic [NGRP:0] cy;

  assign cy[0] = ci;
  assign co    = cy[NGRP];

  initial begin
    p_sizes_r6: assert (base_of(NGRP) == WIDTH)
      else $error("group sizes do not add up to WIDTH");
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int N  = GSZ[g];
    localparam int LO = base_of(g);

    logic [N-1:0] ga, gb;
    logic [N:0]   r0, res;

    assign ga = a[LO +: N];
    assign gb = b[LO +: N];

    if (g == 0) begin : g_base
      always_comb begin
        logic c;
        c = cy[0];
        for (int i = 0; i < N; i++) begin
          r0[i] = ga[i] ^ gb[i] ^ c;
          c     = (ga[i] & gb[i]) | (c & (ga[i] ^ gb[i]));
        end
        r0[N] = c;
      end
      assign res = r0;
    end else begin : g_sel
      logic [N:0] r1;

      always_comb begin
        logic c;
        c = 1'b0;
        for (int i = 0; i < N; i++) begin
          r0[i] = ga[i] ^ gb[i] ^ c;
          c     = (ga[i] & gb[i]) | (c & (ga[i] ^ gb[i]));
        end
        r0[N] = c;
      end

      if (USE_INC) begin : g_inc
        always_comb begin
          logic run;
          run = 1'b1;
          for (int i = 0; i <= N; i++) begin
            r1[i] = r0[i] ^ run;
            run   = run & r0[i];
          end
        end
      end else begin : g_rca1
        always_comb begin
          logic c;
          c = 1'b1;
          for (int i = 0; i < N; i++) begin
            r1[i] = ga[i] ^ gb[i] ^ c;
            c     = (ga[i] & gb[i]) | (c & (ga[i] ^ gb[i]));
          end
          r1[N] = c;
        end
      end

      assign res = cy[g] ? r1 : r0;

      always_comb begin
        p_plus_one_r3: assert (r1 == r0 + 1'b1)
          else $error("group %0d carry-one candidate is not carry-zero plus one", g);
        p_group_r4: assert ({cy[g+1], sum[LO +: N]} == ga + gb + cy[g])
          else $error("group %0d result does not match its carry-in", g);
      end
    end

    assign sum[LO +: N] = res[N-1:0];
    assign cy[g+1]      = res[N];
  end

  always_comb begin
    p_total_r1: assert ({co, sum} == {1'b0, a} + {1'b0, b} + ci)
      else $error("full-width sum mismatch");
  end

endmodule

// File: tb/tb_sqrt_csel_add.sv
module tb_sqrt_csel_add;
  localparam int PERIOD = 10;
  localparam int W = 128;
  localparam int NG = 14;
  localparam int SIZES [NG] = '{2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 24};

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic [W-1:0] a, b, s_inc, s_reg;
  logic ci, co_inc, co_reg;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  sqrt_csel_add #(.USE_INC(1'b1)) dut (
    .a(a), .b(b), .ci(ci), .sum(s_inc), .co(co_inc));
  sqrt_csel_add #(.USE_INC(1'b0)) dut_reg (
    .a(a), .b(b), .ci(ci), .sum(s_reg), .co(co_reg));

  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb,
                       input logic vc, input string tag);
    logic [W:0] exp;
    @(negedge clk);
    a = va; b = vb; ci = vc;
    #(PERIOD/4);
    exp = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
    n_chk++;
    if ({co_inc, s_inc} !== exp) begin
      n_fail++;
      $display("FAIL R1 %s: got %h expected %h", tag, {co_inc, s_inc}, exp);
    end
    n_chk++;
    if ({co_reg, s_reg} !== exp) begin
      n_fail++;
      $display("FAIL R2 %s: got %h expected %h", tag, {co_reg, s_reg}, exp);
    end
  endtask

  task automatic t_zero_r8();
    apply('0, '0, 1'b0, "R8 zero plus zero");
    apply('1, '0, 1'b1, "R8 carry-in across full width");
  endtask

  task automatic t_base_r5();
    apply('0, '0, 1'b1, "R5 carry-in into lowest group");
    apply(128'h3, 128'h1, 1'b1, "R5 lowest group overflow");
  endtask

  task automatic t_wrap_r7();
    apply('1, 128'h1, 1'b0, "R7 all ones plus one ci0");
    apply('1, 128'h1, 1'b1, "R7 all ones plus one ci1");
    apply('1, '1, 1'b1, "R7 all ones plus all ones ci1");
  endtask

  task automatic t_alt_r4();
    apply({32{4'hA}}, {32{4'h5}}, 1'b0, "R4 alternating no carry");
    apply({32{4'hA}}, {32{4'h5}}, 1'b1, "R4 alternating ripple carry");
    apply({32{4'hA}}, {32{4'hA}}, 1'b0, "R4 alternating doubled");
  endtask

  task automatic t_bounds_r6();
    int lo;
    lo = 0;
    for (int g = 0; g < NG - 1; g++) begin
      lo += SIZES[g];
      apply((128'h1 << lo) - 1, 128'h1, 1'b0, $sformatf("R6 carry into group %0d", g + 1));
      apply(128'h1 << (lo - 1), 128'h1 << (lo - 1), 1'b0,
            $sformatf("R6 generate at top of group %0d", g));
    end
  endtask

  task automatic t_random_r3();
    for (int k = 0; k < 300; k++)
      apply({$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom},
            1'($urandom), "R3 random vector");
  endtask

  initial begin
    a = '0; b = '0; ci = 1'b0;
    t_zero_r8();
    t_base_r5();
    t_wrap_r7();
    t_alt_r4();
    t_bounds_r6();
    t_random_r3();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule